// File: doc/BRIEF.md
# Program Counter and Return-Address Stack

This block produces the instruction fetch address for a small 8-bit controller with a 2K-word program store. The 11-bit counter is treated as an 8-bit low byte and a 3-bit high part. Each cycle a decoded operation selects the next address. The counter can step forward, take an absolute jump or call, return from a subroutine or interrupt, or add or subtract the accumulator on the low byte. A separate strobe forces entry to the interrupt vector.

Return addresses live in an eight-entry hardware stack. Calls push the address after the call. An accepted interrupt pushes the address that would have been fetched next. A pop takes the most recently pushed entry. The block reports how many entries are valid, and it has two sticky flags: one for a push into a full stack and one for a pop from an empty stack. A global interrupt-enable output goes low on interrupt entry and high again on return from interrupt.

Top module: `pc_sequencer`

## Requirements
- R1: While reset is asserted, and on leaving it, the fetch address is 0x000, the stack level is 0, both stack flags are 0 and the global enable is 0.
- R2: Operation code 0 (step) loads the fetch address plus one, modulo 2048, so 0x7FF is followed by 0x000.
- R3: Operation code 1 (jump) loads the full 11-bit target, so any address in the 2K space can be reached.
- R4: Operation code 2 (call) pushes the fetch address plus one and loads the target. Operation code 3 (return) loads the popped entry. Each push raises the level by one and each pop lowers it by one.
- R5: When the interrupt strobe is high, the block ignores the operation code for that cycle. It pushes the current fetch address, loads 0x008 and drives the global enable low.
- R6: Operation code 4 (return from interrupt) loads the popped entry and drives the global enable high.
- R7: Operation code 5 (add) replaces the low byte with the low byte plus the accumulator, modulo 256. A carry out of the low byte adds one to the 3-bit high part, and the high part wraps from 7 to 0.
- R8: Operation code 6 (subtract) replaces the low byte with the low byte minus the accumulator, modulo 256. The high part keeps its value even when the subtraction borrows.
- R9: The stack holds eight entries and returns them in last-in, first-out order. The level never exceeds eight.
- R10: A push while eight entries are valid overwrites the oldest entry and leaves the level at eight. It also sets an overflow flag that stays set until reset.
- R11: A pop while the stack is empty loads 0x000 and leaves the level at 0. It also sets an underflow flag that stays set until reset.
- R12: Operation code 7 (hold) leaves the fetch address and the stack unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| op | input | 3 | Decoded operation code (0 step, 1 jump, 2 call, 3 return, 4 return from interrupt, 5 add, 6 subtract, 7 hold) |
| target | input | 11 | Jump or call destination |
| acc | input | 8 | Accumulator value for add and subtract |
| irqTake | input | 1 | Interrupt accepted this cycle |
| fetchAddr | output | 11 | Current program fetch address |
| stackLevel | output | 4 | Number of valid stack entries, 0 to 8 |
| stackOvf | output | 1 | Sticky flag: push into a full stack |
| stackUnf | output | 1 | Sticky flag: pop from an empty stack |
| gieOut | output | 1 | Global interrupt enable |

## Verification
The bench uses the default parameters: an 11-bit address, an 8-bit low byte and a depth of eight. With these values the 0x7FF wrap, the carry out of the high part and the full-stack overwrite can all be reached within a few dozen cycles. A chain of nine calls fills the stack and pushes once more, which shows that the oldest return address is lost. Eight returns then come back in reverse order, and a ninth return exposes the empty-pop behaviour.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

  typedef enum logic [2:0] {
    OP_STEP = 3'd0,
    OP_JUMP = 3'd1,
    OP_CALL = 3'd2,
    OP_RET  = 3'd3,
    OP_RETI = 3'd4,
    OP_ADDA = 3'd5,
    OP_SUBA = 3'd6,
    OP_HOLD = 3'd7
  } seqOp_e;

  typedef enum logic [2:0] {
    SEL_INC,
    SEL_TGT,
    SEL_POP,
    SEL_ADD,
    SEL_SUB,
    SEL_HOLD,
    SEL_IVEC
  } pcSel_e;

  typedef struct packed {
    pcSel_e sel;
    logic   push;
    logic   pushCur;
    logic   pop;
    logic   gieSet;
    logic   gieClr;
  } seqCtrl_t;

endpackage

// File: rtl/pcseq_ctrl.sv
module pcseq_ctrl
  import pcseq_pkg::*;
(
  input  logic [2:0] op,
  input  logic       irqTake,
  output seqCtrl_t   ctrl
);

  seqOp_e opDec;
  assign opDec = seqOp_e'(op);

  always_comb begin
    ctrl = '{sel: SEL_HOLD, push: 1'b0, pushCur: 1'b0, pop: 1'b0,
             gieSet: 1'b0, gieClr: 1'b0};
    if (irqTake) begin
      ctrl.sel     = SEL_IVEC;
      ctrl.push    = 1'b1;
      ctrl.pushCur = 1'b1;
      ctrl.gieClr  = 1'b1;
    end else begin
      unique case (opDec)
        OP_STEP: ctrl.sel = SEL_INC;
        OP_JUMP: ctrl.sel = SEL_TGT;
        OP_CALL: begin
          ctrl.sel  = SEL_TGT;
          ctrl.push = 1'b1;
        end
        OP_RET: begin
          ctrl.sel = SEL_POP;
          ctrl.pop = 1'b1;
        end
        OP_RETI: begin
          ctrl.sel    = SEL_POP;
          ctrl.pop    = 1'b1;
          ctrl.gieSet = 1'b1;
        end
        OP_ADDA: ctrl.sel = SEL_ADD;
        OP_SUBA: ctrl.sel = SEL_SUB;
        default: ctrl.sel = SEL_HOLD;
      endcase
    end
  end

endmodule

// File: rtl/pcseq_stack.sv
module pcseq_stack #(
  parameter int ADDR_W = 11,
  parameter int DEPTH  = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              push,
  input  logic              pop,
  input  logic [ADDR_W-1:0] pushData,
  output logic [ADDR_W-1:0] popData,
  output logic [LVL_W-1:0]  level,
  output logic              ovf,
  output logic              unf
);

  logic [ADDR_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  nextPtr;
  logic [PTR_W-1:0]  prevPtr;
  logic              isFull;
  logic              isEmpty;

  assign nextPtr = (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + PTR_W'(1);
  assign prevPtr = (wrPtr == '0) ? PTR_W'(DEPTH - 1) : wrPtr - PTR_W'(1);
  assign isFull  = (level == LVL_W'(DEPTH));
  assign isEmpty = (level == '0);
  assign popData = isEmpty ? '0 : mem[prevPtr];

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_entry
      always_ff @(posedge clk) begin
        if (push && (wrPtr == PTR_W'(gi))) mem[gi] <= pushData;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      level <= '0;
      ovf   <= 1'b0;
      unf   <= 1'b0;
    end else if (push) begin
      wrPtr <= nextPtr;
      if (isFull) ovf <= 1'b1;
      else        level <= level + LVL_W'(1);
    end else if (pop) begin
      if (isEmpty) begin
        unf <= 1'b1;
      end else begin
        wrPtr <= prevPtr;
        level <= level - LVL_W'(1);
      end
    end
  end

endmodule

// File: rtl/pcseq_datapath.sv
module pcseq_datapath
  import pcseq_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int DATA_W   = 8,
  parameter int DEPTH    = 8,
  parameter int IRQ_VEC  = 8,
  parameter int RST_VEC  = 0,
  localparam int HI_W    = ADDR_W - DATA_W,
  localparam int LVL_W   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtrl_t          ctrl,
  input  logic [ADDR_W-1:0] target,
  input  logic [DATA_W-1:0] acc,
  output logic [ADDR_W-1:0] pcOut,
  output logic [LVL_W-1:0]  level,
  output logic              ovf,
  output logic              unf,
  output logic              gie
);

  logic [ADDR_W-1:0] pcQ;
  logic [ADDR_W-1:0] pcD;
  logic [ADDR_W-1:0] pcInc;
  logic [ADDR_W-1:0] popData;
  logic [ADDR_W-1:0] pushData;
  logic [DATA_W-1:0] lowQ;
  logic [HI_W-1:0]   highQ;
  logic [DATA_W:0]   addSum;
  logic [DATA_W-1:0] subLow;

  assign lowQ     = pcQ[DATA_W-1:0];
  assign highQ    = pcQ[ADDR_W-1:DATA_W];
  assign pcInc    = pcQ + ADDR_W'(1);
  assign addSum   = {1'b0, lowQ} + {1'b0, acc};
  assign subLow   = lowQ - acc;
  assign pushData = ctrl.pushCur ? pcQ : pcInc;

  always_comb begin
    unique case (ctrl.sel)
      SEL_INC:  pcD = pcInc;
      SEL_TGT:  pcD = target;
      SEL_POP:  pcD = popData;
      SEL_ADD:  pcD = {highQ + HI_W'(addSum[DATA_W]), addSum[DATA_W-1:0]};
      SEL_SUB:  pcD = {highQ, subLow};
      SEL_IVEC: pcD = ADDR_W'(IRQ_VEC);
      default:  pcD = pcQ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ <= ADDR_W'(RST_VEC);
      gie <= 1'b0;
    end else begin
      pcQ <= pcD;
      if (ctrl.gieClr)      gie <= 1'b0;
      else if (ctrl.gieSet) gie <= 1'b1;
    end
  end

  assign pcOut = pcQ;

  pcseq_stack #(
    .ADDR_W(ADDR_W),
    .DEPTH (DEPTH)
  ) u_stack (
    .clk     (clk),
    .rstN    (rstN),
    .push    (ctrl.push),
    .pop     (ctrl.pop),
    .pushData(pushData),
    .popData (popData),
    .level   (level),
    .ovf     (ovf),
    .unf     (unf)
  );

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pcseq_pkg::*;
#(
  parameter int ADDR_W  = 11,
  parameter int DATA_W  = 8,
  parameter int DEPTH   = 8,
  parameter int IRQ_VEC = 8,
  parameter int RST_VEC = 0,
  localparam int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        op,
  input  logic [ADDR_W-1:0] target,
  input  logic [DATA_W-1:0] acc,
  input  logic              irqTake,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic [LVL_W-1:0]  stackLevel,
  output logic              stackOvf,
  output logic              stackUnf,
  output logic              gieOut
);

  seqCtrl_t ctrl;

  pcseq_ctrl u_ctrl (
    .op     (op),
    .irqTake(irqTake),
    .ctrl   (ctrl)
  );

  pcseq_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .IRQ_VEC(IRQ_VEC),
    .RST_VEC(RST_VEC)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .ctrl  (ctrl),
    .target(target),
    .acc   (acc),
    .pcOut (fetchAddr),
    .level (stackLevel),
    .ovf   (stackOvf),
    .unf   (stackUnf),
    .gie   (gieOut)
  );

endmodule

// File: rtl/pcseq_checker.sv
module pcseq_checker #(
  parameter int ADDR_W  = 11,
  parameter int DEPTH   = 8,
  parameter int IRQ_VEC = 8,
  localparam int LVL_W  = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        op,
  input logic              irqTake,
  input logic [ADDR_W-1:0] fetchAddr,
  input logic [LVL_W-1:0]  stackLevel,
  input logic              stackOvf,
  input logic              stackUnf,
  input logic              gieOut
);

  assert_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!irqTake && op == 3'd0) |=> fetchAddr == $past(fetchAddr) + ADDR_W'(1));

  assert_irq_vector_R5: assert property (@(posedge clk) disable iff (!rstN)
    irqTake |=> (fetchAddr == ADDR_W'(IRQ_VEC)) && !gieOut);

  assert_reti_gie_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!irqTake && op == 3'd4) |=> gieOut);

  assert_sub_high_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!irqTake && op == 3'd6) |=> fetchAddr[ADDR_W-1:8] == $past(fetchAddr[ADDR_W-1:8]));

  assert_level_bound_R9: assert property (@(posedge clk) disable iff (!rstN)
    stackLevel <= LVL_W'(DEPTH));

  assert_no_overflow_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    stackOvf |=> stackOvf);

  assert_no_underflow_clear_R11: assert property (@(posedge clk) disable iff (!rstN)
    stackUnf |=> stackUnf);

  assert_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (!irqTake && op == 3'd7) |=> $stable(fetchAddr) && $stable(stackLevel));

endmodule

bind pc_sequencer pcseq_checker #(
  .ADDR_W (ADDR_W),
  .DEPTH  (DEPTH),
  .IRQ_VEC(IRQ_VEC)
) u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .op        (op),
  .irqTake   (irqTake),
  .fetchAddr (fetchAddr),
  .stackLevel(stackLevel),
  .stackOvf  (stackOvf),
  .stackUnf  (stackUnf),
  .gieOut    (gieOut)
);

// File: tb/test_pc_sequencer.sv
module test_pc_sequencer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  op = 3'd7;
  logic [10:0] target = '0;
  logic [7:0]  acc = '0;
  logic        irqTake = 1'b0;
  logic [10:0] fetchAddr;
  logic [3:0]  stackLevel;
  logic        stackOvf;
  logic        stackUnf;
  logic        gieOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  pc_sequencer i_pc_sequencer (
    .clk       (clk),
    .rstN      (rstN),
    .op        (op),
    .target    (target),
    .acc       (acc),
    .irqTake   (irqTake),
    .fetchAddr (fetchAddr),
    .stackLevel(stackLevel),
    .stackOvf  (stackOvf),
    .stackUnf  (stackUnf),
    .gieOut    (gieOut)
  );

  // {op[3], irq[1], target[11], acc[8], expPc[11], expLevel[4], expGie[1]}
  localparam int NV = 18;
  localparam logic [38:0] VECS [NV] = '{
    {3'd0, 1'b0, 11'h000, 8'h00, 11'h001, 4'd0, 1'b0}, // R2 step
    {3'd1, 1'b0, 11'h7FE, 8'h00, 11'h7FE, 4'd0, 1'b0}, // R3 jump high
    {3'd0, 1'b0, 11'h000, 8'h00, 11'h7FF, 4'd0, 1'b0}, // R2
    {3'd0, 1'b0, 11'h000, 8'h00, 11'h000, 4'd0, 1'b0}, // R2 wrap
    {3'd1, 1'b0, 11'h0F0, 8'h00, 11'h0F0, 4'd0, 1'b0}, // R3
    {3'd5, 1'b0, 11'h000, 8'h20, 11'h110, 4'd0, 1'b0}, // R7 carry
    {3'd6, 1'b0, 11'h000, 8'h20, 11'h1F0, 4'd0, 1'b0}, // R8 borrow
    {3'd6, 1'b0, 11'h000, 8'h10, 11'h1E0, 4'd0, 1'b0}, // R8
    {3'd5, 1'b0, 11'h000, 8'h05, 11'h1E5, 4'd0, 1'b0}, // R7 no carry
    {3'd1, 1'b0, 11'h7F0, 8'h00, 11'h7F0, 4'd0, 1'b0}, // R3
    {3'd5, 1'b0, 11'h000, 8'h20, 11'h010, 4'd0, 1'b0}, // R7 high wraps
    {3'd2, 1'b0, 11'h345, 8'h00, 11'h345, 4'd1, 1'b0}, // R4 call
    {3'd2, 1'b0, 11'h200, 8'h00, 11'h200, 4'd2, 1'b0}, // R4 call
    {3'd7, 1'b0, 11'h000, 8'h00, 11'h200, 4'd2, 1'b0}, // R12 hold
    {3'd1, 1'b1, 11'h777, 8'h00, 11'h008, 4'd3, 1'b0}, // R5 irq wins
    {3'd4, 1'b0, 11'h000, 8'h00, 11'h200, 4'd2, 1'b1}, // R6 reti
    {3'd3, 1'b0, 11'h000, 8'h00, 11'h346, 4'd1, 1'b1}, // R4 return
    {3'd3, 1'b0, 11'h000, 8'h00, 11'h011, 4'd0, 1'b1}  // R4 R9 order
  };

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic apply(input logic [2:0] o, input logic [10:0] t,
                       input logic [7:0] a, input logic irq);
    op = o; target = t; acc = a; irqTake = irq;
    @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: got hung expected finish");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 state during reset
    check("R1 pc in reset", int'(fetchAddr), 0);
    check("R1 level in reset", int'(stackLevel), 0);
    check("R1 gie in reset", int'(gieOut), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 pc after reset", int'(fetchAddr), 0);
    check("R1 flags after reset", int'({stackOvf, stackUnf}), 0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i][38:36], VECS[i][34:24], VECS[i][23:16], VECS[i][35]);
      check($sformatf("vector %0d pc", i), int'(fetchAddr), int'(VECS[i][15:5]));
      check($sformatf("vector %0d level", i), int'(stackLevel), int'(VECS[i][4:1]));
      check($sformatf("vector %0d gie", i), int'(gieOut), int'(VECS[i][0]));
    end
    check("R11 no underflow yet", int'(stackUnf), 0);

    // Reset again, then fill past depth: R9 R10
    rstN = 1'b0;
    @(negedge clk);
    check("R1 pc re-reset", int'(fetchAddr), 0);
    check("R1 gie re-reset", int'(gieOut), 0);
    rstN = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 9; i++) begin
      apply(3'd2, 11'h100 + 11'(i), 8'h00, 1'b0);
      check("R9 level while filling", int'(stackLevel), (i < 8) ? i + 1 : 8);
      check("R10 overflow flag", int'(stackOvf), (i == 8) ? 1 : 0);
    end
    // Stack holds 101..108; the first return address 001 was overwritten
    for (int i = 0; i < 8; i++) begin
      apply(3'd3, 11'h000, 8'h00, 1'b0);
      check("R9 R10 LIFO pop", int'(fetchAddr), 'h108 - i);
      check("R9 level while draining", int'(stackLevel), 7 - i);
    end
    check("R10 overflow sticky", int'(stackOvf), 1);
    // R11 pop from empty
    apply(3'd3, 11'h000, 8'h00, 1'b0);
    check("R11 empty pop pc", int'(fetchAddr), 0);
    check("R11 empty pop level", int'(stackLevel), 0);
    check("R11 underflow flag", int'(stackUnf), 1);
    apply(3'd0, 11'h000, 8'h00, 1'b0);
    check("R11 underflow sticky", int'(stackUnf), 1);
    check("R2 step after underflow", int'(fetchAddr), 1);
    // R12 hold across cycles
    apply(3'd7, 11'h555, 8'hFF, 1'b0);
    apply(3'd7, 11'h555, 8'hFF, 1'b0);
    check("R12 hold pc", int'(fetchAddr), 1);
    check("R12 hold level", int'(stackLevel), 0);
    // R8 subtract without borrow on a high page
    apply(3'd1, 11'h6A0, 8'h00, 1'b0);
    apply(3'd6, 11'h000, 8'h20, 1'b0);
    check("R8 sub no borrow", int'(fetchAddr), 'h680);
    apply(3'd6, 11'h000, 8'hFF, 1'b0);
    check("R8 sub borrow keeps high", int'(fetchAddr), 'h681);
    // R5 irq pushes current address, R6 returns to it
    apply(3'd0, 11'h000, 8'h00, 1'b1);
    check("R5 irq vector", int'(fetchAddr), 8);
    apply(3'd4, 11'h000, 8'h00, 1'b0);
    check("R6 reti address", int'(fetchAddr), 'h681);
    check("R6 reti gie", int'(gieOut), 1);

    finishRun();
  end

endmodule